// File: doc/BRIEF.md
# Q15 FIR Multiply-Accumulate Datapath

This block is a sample-driven finite impulse response filter core for signed 16-bit fixed-point data. A one-cycle sample strobe pushes a new input word into a tap delay line. Each stored sample moves one place further back, and the oldest falls off the end. A sequencer then walks the taps one per cycle, from the oldest sample to the newest. Each sample is multiplied by its coefficient, and each product passes through a selectable shift before it is added into a 32-bit accumulator. A product register sits between the multiplier and the adder, so the final product is added in a drain step after the last multiply. The output word is the upper half of the finished sum with its two lowest bits cleared. A one-cycle done pulse marks it.

Coefficients are loaded through a plain write port. Tap index 0 weights the newest sample. After reset every coefficient holds 8192, which is 0.25 in Q15. With the default of four taps and the left-by-one shift mode, the core therefore computes a four-point moving average. The sequencer has four named states:
- `ST_IDLE` waits for a strobe and takes the IDLE→FILL transition when one arrives.
- `ST_FILL` issues the first multiply.
- `ST_MAC` multiplies the next tap while adding the previous product. It takes MAC→MAC while taps remain and MAC→DRAIN after tap 0. FILL→DRAIN is taken directly only for a single tap.
- `ST_DRAIN` adds the last product and returns DRAIN→IDLE.

Top module: `q15_fir_mac`

## Requirements
- R1: After reset, `busy`, `done` and `result` are 0, every sample slot holds 0 and every coefficient holds 8192.
- R2: An accepted sample is stored as the newest (slot 0). Every older sample moves one slot back, slot k becoming slot k+1, and the sample in slot TAPS-1 is discarded.
- R3: Each product (a signed 16×16 multiply, sign-extended to 32 bits) is shifted according to `shift_mode` before accumulation. The encodings are 2'b00 no shift, 2'b01 arithmetic left by 1, 2'b10 arithmetic left by 4, and 2'b11 arithmetic right by 4 with sign fill.
- R4: The 32-bit accumulator starts at zero for every sample and wraps in two's complement on overflow, without saturation.
- R5: `result` equals bits 31:18 of the final sum, with bits 1:0 forced to 0. It holds its value between done pulses.
- R6: `done` is high for exactly one cycle, TAPS+1 clock edges after the edge that accepts the sample.
- R7: `busy` is high from the edge after acceptance until the edge on which `done` rises. A strobe seen while `busy` is high is ignored: it neither ages the delay line nor starts a computation.
- R8: A write with `coef_we` high, while idle, replaces the coefficient of tap `coef_addr`. Tap 0 multiplies the newest sample and tap TAPS-1 the oldest. Later samples use the new value.
- R9: The shift mode is captured on the accepting edge. Changes to `shift_mode` while `busy` is high do not affect that computation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid | input | 1 | One-cycle strobe offering a new sample |
| sample_in | input | 16 | Signed Q15 input sample |
| shift_mode | input | 2 | Product shift selection, captured at acceptance |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | $clog2(TAPS) | Tap index being written |
| coef_data | input | 16 | Signed Q15 coefficient value |
| busy | output | 1 | Computation in progress; strobes are ignored |
| done | output | 1 | One-cycle pulse, `result` updated |
| result | output | 16 | Filter output, two low bits zero |

## Verification
A ramp of mixed-sign samples under the default coefficients checks the moving average and shows that each output averages the right four samples. A coefficient set with a single non-zero tap at the newest slot, and then one at the oldest slot, tells apart correct aging from an off-by-one or reversed delay line. The same history is run through all four shift encodings, and full-scale operands in the left-by-four mode force the accumulator to wrap, which separates wrapping from saturation or a wider sum. Strobes injected while busy, and a shift-mode change in mid-computation, show whether either leaks into the history or the result.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;

    typedef enum logic [1:0] {
        PSH_NONE = 2'b00,
        PSH_L1   = 2'b01,
        PSH_L4   = 2'b10,
        PSH_R4   = 2'b11
    } pshift_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_MAC,
        ST_DRAIN
    } fir_state_e;

    localparam int unsigned MAX_TAPS = 128;

endpackage

// File: rtl/fir_tap_store.sv
module fir_tap_store #(
    parameter int unsigned TAPS      = 4,
    parameter int unsigned DW        = 16,
    parameter int unsigned IDXW      = 2,
    parameter int signed   COEF_INIT = 8192
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic signed [DW-1:0] din,
    input  logic                 coef_we,
    input  logic [IDXW-1:0]      coef_addr,
    input  logic signed [DW-1:0] coef_data,
    input  logic [IDXW-1:0]      rd_idx,
    output logic signed [DW-1:0] x_rd,
    output logic signed [DW-1:0] c_rd
);

    localparam logic signed [DW-1:0] C_RST = DW'(COEF_INIT);

    logic signed [DW-1:0] hist_q [TAPS];
    logic signed [DW-1:0] coef_q [TAPS];

    for (genvar g = 0; g < TAPS; g++) begin : g_slot
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        hist_q[g] <= '0;
                else if (shift_en) hist_q[g] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        hist_q[g] <= '0;
                else if (shift_en) hist_q[g] <= hist_q[g-1];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                coef_q[g] <= C_RST;
            else if (coef_we && (coef_addr == IDXW'(g)))
                coef_q[g] <= coef_data;
        end
    end

    assign x_rd = hist_q[rd_idx];
    assign c_rd = coef_q[rd_idx];

endmodule

// File: rtl/fir_mac_unit.sv
module fir_mac_unit
    import fir_mac_pkg::*;
#(
    parameter int unsigned DW    = 16,
    parameter int unsigned ACC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    mul_en,
    input  logic                    add_en,
    input  pshift_e                 mode,
    input  logic signed [DW-1:0]    x,
    input  logic signed [DW-1:0]    c,
    output logic signed [ACC_W-1:0] acc_next
);

    localparam int unsigned PW = 2 * DW;

    logic signed [PW-1:0]    prod_q;
    logic signed [ACC_W-1:0] prod_ext;
    logic signed [ACC_W-1:0] prod_sh;
    logic signed [ACC_W-1:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      prod_q <= '0;
        else if (mul_en) prod_q <= x * c;
    end

    assign prod_ext = ACC_W'(prod_q);

    always_comb begin
        unique case (mode)
            PSH_NONE: prod_sh = prod_ext;
            PSH_L1:   prod_sh = prod_ext <<< 1;
            PSH_L4:   prod_sh = prod_ext <<< 4;
            PSH_R4:   prod_sh = prod_ext >>> 4;
        endcase
    end

    assign acc_next = acc_q + prod_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc_q <= '0;
        else if (clr)    acc_q <= '0;
        else if (add_en) acc_q <= acc_next;
    end

endmodule

// File: rtl/fir_seq.sv
module fir_seq
    import fir_mac_pkg::*;
#(
    parameter int unsigned TAPS = 4,
    parameter int unsigned IDXW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sample_valid,
    input  logic [1:0]      mode_in,
    output logic [IDXW-1:0] idx,
    output pshift_e         mode_q,
    output logic            accept,
    output logic            mul_en,
    output logic            add_en,
    output logic            finish,
    output logic            busy
);

    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(TAPS - 1);

    fir_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (sample_valid) st_d = ST_FILL;
            ST_FILL,
            ST_MAC:   st_d = (idx == '0) ? ST_DRAIN : ST_MAC;
            ST_DRAIN: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept = (st_q == ST_IDLE) && sample_valid;
        mul_en = (st_q == ST_FILL) || (st_q == ST_MAC);
        add_en = (st_q == ST_MAC)  || (st_q == ST_DRAIN);
        finish = (st_q == ST_DRAIN);
        busy   = (st_q != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx    <= '0;
            mode_q <= PSH_NONE;
        end else if (accept) begin
            idx    <= LAST_IDX;
            mode_q <= pshift_e'(mode_in);
        end else if (mul_en && (idx != '0)) begin
            idx    <= idx - 1'b1;
        end
    end

endmodule

// File: rtl/q15_fir_mac.sv
module q15_fir_mac
    import fir_mac_pkg::*;
#(
    parameter int unsigned TAPS      = 4,
    parameter int unsigned DW        = 16,
    parameter int unsigned ACC_W     = 32,
    parameter int signed   COEF_INIT = 8192,
    localparam int unsigned IDXW     = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sample_valid,
    input  logic [DW-1:0]   sample_in,
    input  logic [1:0]      shift_mode,
    input  logic            coef_we,
    input  logic [IDXW-1:0] coef_addr,
    input  logic [DW-1:0]   coef_data,
    output logic            busy,
    output logic            done,
    output logic [DW-1:0]   result
);

    localparam int unsigned CLR_BITS = 2;

    logic [IDXW-1:0]      rd_idx;
    pshift_e              mode_q;
    logic                 accept, mul_en, add_en, finish;
    logic signed [DW-1:0] x_rd, c_rd;
    logic signed [ACC_W-1:0] acc_next;
    logic [DW-1:0]        hi_word;

    fir_seq #(.TAPS(TAPS), .IDXW(IDXW)) u_seq (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .mode_in(shift_mode), .idx(rd_idx), .mode_q(mode_q),
        .accept(accept), .mul_en(mul_en), .add_en(add_en),
        .finish(finish), .busy(busy)
    );

    fir_tap_store #(.TAPS(TAPS), .DW(DW), .IDXW(IDXW), .COEF_INIT(COEF_INIT)) u_store (
        .clk(clk), .rst_n(rst_n), .shift_en(accept), .din(sample_in),
        .coef_we(coef_we && !busy), .coef_addr(coef_addr), .coef_data(coef_data),
        .rd_idx(rd_idx), .x_rd(x_rd), .c_rd(c_rd)
    );

    fir_mac_unit #(.DW(DW), .ACC_W(ACC_W)) u_mac (
        .clk(clk), .rst_n(rst_n), .clr(accept), .mul_en(mul_en),
        .add_en(add_en), .mode(mode_q), .x(x_rd), .c(c_rd),
        .acc_next(acc_next)
    );

    assign hi_word = acc_next[ACC_W-1 -: DW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= finish;
            if (finish)
                result <= {hi_word[DW-1:CLR_BITS], {CLR_BITS{1'b0}}};
        end
    end

endmodule

// File: rtl/q15_fir_mac_chk.sv
module q15_fir_mac_chk #(
    parameter int unsigned TAPS = 4,
    parameter int unsigned DW   = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sample_valid,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] result
);

    logic [7:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r6_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= 8'(TAPS + 1));

    a_r7_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !busy) |=> busy);

    a_r7_no_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r5_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    a_r5_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (result[1:0] == 2'b00));

endmodule

bind q15_fir_mac q15_fir_mac_chk #(.TAPS(TAPS), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .busy(busy), .done(done), .result(result)
);

// File: tb/q15_fir_mac_test.sv
module q15_fir_mac_test;

    localparam int TAPS = 4;
    localparam int IDXW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sample_valid = 1'b0;
    logic [15:0]     sample_in = '0;
    logic [1:0]      shift_mode = 2'b01;
    logic            coef_we = 1'b0;
    logic [IDXW-1:0] coef_addr = '0;
    logic [15:0]     coef_data = '0;
    logic            busy, done;
    logic [15:0]     result;

    q15_fir_mac #(.TAPS(TAPS)) uut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .sample_in(sample_in), .shift_mode(shift_mode), .coef_we(coef_we),
        .coef_addr(coef_addr), .coef_data(coef_data), .busy(busy),
        .done(done), .result(result)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [15:0] exp;
        int          t0;
        string       tag;
    } item_t;

    item_t sb[$];
    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic signed [15:0] mh [TAPS];
    logic signed [15:0] mc [TAPS];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    function automatic logic [15:0] model(input logic [1:0] m);
        logic signed [31:0] acc, p;
        acc = 0;
        for (int i = TAPS - 1; i >= 0; i--) begin
            p = mh[i] * mc[i];
            case (m)
                2'b00: p = p;
                2'b01: p = p <<< 1;
                2'b10: p = p <<< 4;
                default: p = p >>> 4;
            endcase
            acc = acc + p;
        end
        return {acc[31:18], 2'b00};
    endfunction

    task automatic send(input logic [15:0] x, input logic [1:0] m, input string tag);
        item_t it;
        @(negedge clk);
        while (busy) @(negedge clk);
        sample_in    = x;
        shift_mode   = m;
        sample_valid = 1'b1;
        for (int i = TAPS - 1; i > 0; i--) mh[i] = mh[i-1];
        mh[0] = x;
        it.exp = model(m);
        it.tag = tag;
        @(posedge clk);
        #1;
        it.t0 = cyc;
        sb.push_back(it);
        chk(busy == 1'b1, "R7", "busy after accept", busy, 1);
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic wr_coef(input int a, input logic [15:0] v);
        @(negedge clk);
        while (busy || sb.size() != 0) @(negedge clk);
        coef_we   = 1'b1;
        coef_addr = IDXW'(a);
        coef_data = v;
        mc[a]     = v;
        @(negedge clk);
        coef_we   = 1'b0;
    endtask

    // monitor: pops expected items as results appear
    initial begin
        logic prev_done;
        prev_done = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            if (done) begin
                chk(!prev_done, "R6", "done longer than one cycle", 1, 0);
                if (sb.size() == 0) begin
                    chk(1'b0, "R7", "unexpected done", 1, 0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    chk(result == it.exp, it.tag, "result", result, it.exp);
                    chk(result[1:0] == 2'b00, "R5", "low bits", result[1:0], 0);
                    chk(cyc - it.t0 == TAPS + 1, "R6", "latency", cyc - it.t0, TAPS + 1);
                end
            end
            prev_done = done;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL R6 watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < TAPS; i++) begin
            mh[i] = '0;
            mc[i] = 16'sd8192;
        end
        repeat (3) @(posedge clk);
        #1;
        chk(busy == 1'b0, "R1", "busy at reset", busy, 0);
        chk(done == 1'b0, "R1", "done at reset", done, 0);
        chk(result == 16'h0, "R1", "result at reset", result, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2: moving average with default coefficients
        send(16'd4000,  2'b01, "R1");
        send(16'd8000,  2'b01, "R2");
        send(-16'sd1200, 2'b01, "R2");
        send(16'd100,   2'b01, "R2");
        send(16'd20000, 2'b01, "R2");
        send(-16'sd32768, 2'b01, "R2");

        // R3: all shift encodings on the same history
        send(16'd12345, 2'b00, "R3");
        send(-16'sd777, 2'b10, "R3");
        send(16'd3000,  2'b11, "R3");
        send(-16'sd5000, 2'b11, "R3");
        send(16'd2222,  2'b00, "R3");

        // R8 R2: single tap at newest, then at oldest
        wr_coef(0, 16'h7fff);
        wr_coef(1, 16'h0000);
        wr_coef(2, 16'h0000);
        wr_coef(3, 16'h0000);
        send(16'd9000,  2'b01, "R8");
        send(-16'sd4444, 2'b01, "R8");
        wr_coef(0, 16'h0000);
        wr_coef(3, 16'h7fff);
        send(16'd1, 2'b01, "R2");
        send(16'd2, 2'b01, "R2");
        send(16'd3, 2'b01, "R2");
        send(16'd4, 2'b01, "R2");

        // R4: full-scale operands force wrap
        for (int i = 0; i < TAPS; i++) wr_coef(i, 16'h7fff);
        for (int i = 0; i < TAPS; i++) send(16'h7fff, 2'b10, "R4");
        send(16'h8000, 2'b10, "R4");
        send(16'h8000, 2'b01, "R4");

        // R7: strobe while busy is ignored
        wr_coef(0, 16'd1000);
        wr_coef(1, 16'd2000);
        wr_coef(2, 16'd3000);
        wr_coef(3, 16'd4000);
        send(16'd500, 2'b01, "R7");
        sample_in    = 16'd31111;
        sample_valid = 1'b1;
        #1;
        chk(busy == 1'b1, "R7", "busy during extra strobe", busy, 1);
        @(negedge clk);
        sample_valid = 1'b0;
        send(16'd600, 2'b01, "R7");

        // R9: mode change during computation
        send(16'd7000, 2'b01, "R9");
        shift_mode = 2'b11;
        send(-16'sd7000, 2'b00, "R9");
        shift_mode = 2'b10;

        while (sb.size() != 0) @(posedge clk);
        repeat (10) @(posedge clk);
        #1;
        chk(done == 1'b0 && busy == 1'b0, "R6", "quiet at end", {busy, done}, 0);
        summary();
        $finish;
    end

endmodule